// File: doc/BRIEF.md
# Conditional register or memory writer

This block runs one conditional-store command. The command arrives as seven 32-bit words on a simple word stream. The block fetches one 32-bit value, either from the register file or from memory. It ANDs that value with a mask and compares the result once against a reference. If the test passes, it stores a data word to a register or to a memory location. The source and the destination are picked independently by two control bits, so all four combinations of register and memory are legal.

A failed test is not retried. The block skips the write, signals completion and returns to accepting words. An unknown comparison code or an out-of-range register address ends the command with an error flag and no write. Memory words are big-endian. The block swaps bytes on the way in and on the way out, so the rest of the chip sees a plain byte-lane bus.

Top module: `cond_store_engine`

## Requirements
- R1: Command words are taken in this order: control, poll address, reference, mask, wait, write address, write data. `word_ready` is high only while the block is collecting words; a word is taken on a clock edge where `word_valid` and `word_ready` are both high. Idle cycles between words do not shift the order.
- R2: Control bit 4 picks the compared source: 1 reads memory at the poll address, 0 reads the register at the poll address.
- R3: Control bit 8 picks the destination: 1 issues a memory write, 0 issues a register write. This choice is independent of bit 4, and at most one write strobe is high in any cycle.
- R4: Control bits 2:0 select the test of `(value & mask)` against the reference, as unsigned 32-bit numbers: 0 always passes, 1 is <, 2 is <=, 3 is ==, 4 is !=, 5 is >=, 6 is >.
- R5: The source is read exactly once per command. A failed test produces no write, and the command still completes.
- R6: Memory is big-endian: the byte at the word address is the most significant byte. On the memory buses, byte lane k (bits 8k+7:8k) carries the byte at address+k.
- R7: A register access requires an address below `REG_COUNT`. A register poll address or register write address at or above it ends the command with `err` set and no write. A memory write address is not range-checked.
- R8: The wait word is accepted and has no effect on the outcome.
- R9: Comparison code 7 ends the command with `err` set, no source read and no write.
- R10: `done` is a one-cycle pulse. It comes the cycle after the write strobe, or after the decision not to write. `err` is valid only together with `done`.
- R11: After reset, `word_ready` is high, and `done`, `err` and all read and write strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Command word present |
| word_data | input | 32 | Command word |
| word_ready | output | 1 | Block is collecting command words |
| reg_rd_en | output | 1 | Register read strobe; data returns the next cycle |
| reg_rd_addr | output | REG_AW | Register read address |
| reg_rd_data | input | 32 | Register read data, one cycle after the strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | REG_AW | Register write address |
| reg_wr_data | output | 32 | Register write data |
| mem_rd_req | output | 1 | Memory read request, one-cycle pulse |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | 32 | Memory read data, byte lane k = address+k |
| mem_wr_req | output | 1 | Memory write request, one-cycle pulse |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data, byte lane k = address+k |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Command ended in error; valid with done |

## Verification
The bench runs every comparison code against references just below, equal to and just above the masked value. A swapped or off-by-one operator then shows up as a write that is missing or extra. It drives all four source and destination pairings and checks byte placement in memory. A block that ignores one select bit, or ties the destination to the source, writes the wrong port. A block with the byte order reversed misses the match and scrambles the stored bytes. It also sends commands that fail the test, use code 7, or use register addresses just at the limit. Each must finish with exactly one read at most, no write and a single `done`. Retry logic would show up as extra reads or a hang, and a missing range check as a stray write.

// File: rtl/cse_pkg.sv
package cse_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_WORDS = 7;

    // Position of each word in the command stream (order is behaviour)
    localparam int IDX_CTRL  = 0;
    localparam int IDX_POLL  = 1;
    localparam int IDX_REF   = 2;
    localparam int IDX_MASK  = 3;
    localparam int IDX_WAIT  = 4;
    localparam int IDX_WADDR = 5;
    localparam int IDX_WDATA = 6;

    // Control word fields
    localparam int CTL_SRC_MEM = 4;
    localparam int CTL_DST_MEM = 8;
    localparam int CTL_CODE_LO = 0;
    localparam int CTL_CODE_W  = 3;

    typedef enum logic [2:0] {
        CMP_ALWAYS = 3'd0,
        CMP_LT     = 3'd1,
        CMP_LE     = 3'd2,
        CMP_EQ     = 3'd3,
        CMP_NE     = 3'd4,
        CMP_GE     = 3'd5,
        CMP_GT     = 3'd6,
        CMP_BAD    = 3'd7
    } cmp_e;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_ISSUE,
        ST_RESP,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } state_e;

endpackage

// File: rtl/cse_payload.sv
module cse_payload #(
    parameter int NWORDS = 7,
    parameter int W      = 32,
    localparam int CNT_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [W-1:0]             din,
    output logic [NWORDS-1:0][W-1:0] words,
    output logic                     last
);

    typedef struct packed {
        logic [CNT_W-1:0]         cnt;
        logic [NWORDS-1:0][W-1:0] words;
    } pay_t;

    pay_t pay_d, pay_q;

    always_comb begin
        pay_d = pay_q;
        last  = 1'b0;
        if (load) begin
            pay_d.words[pay_q.cnt] = din;
            if (pay_q.cnt == CNT_W'(NWORDS - 1)) begin
                pay_d.cnt = '0;
                last      = 1'b1;
            end else begin
                pay_d.cnt = pay_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_q <= '0;
        end else begin
            pay_q <= pay_d;
        end
    end

    assign words = pay_q.words;

    // Word counter never leaves the payload length (R1)
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pay_q.cnt < CNT_W'(NWORDS));

endmodule

// File: rtl/cse_compare.sv
module cse_compare
    import cse_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   code,
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] refv,
    output logic         match,
    output logic         bad
);

    logic [W-1:0] masked;

    always_comb begin
        masked = value & mask;
        match  = 1'b0;
        bad    = 1'b0;
        case (code)
            CMP_ALWAYS: match = 1'b1;
            CMP_LT:     match = masked <  refv;
            CMP_LE:     match = masked <= refv;
            CMP_EQ:     match = masked == refv;
            CMP_NE:     match = masked != refv;
            CMP_GE:     match = masked >= refv;
            CMP_GT:     match = masked >  refv;
            default:    bad   = 1'b1;
        endcase
    end

endmodule

// File: rtl/cse_byteswap.sv
module cse_byteswap #(
    parameter int W = 32,
    localparam int NB = W / 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

endmodule

// File: rtl/cond_store_engine.sv
module cond_store_engine
    import cse_pkg::*;
#(
    parameter int REG_COUNT = 48,
    parameter int ADDR_W    = 32,
    localparam int REG_AW   = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [31:0]       word_data,
    output logic              word_ready,
    output logic              reg_rd_en,
    output logic [REG_AW-1:0] reg_rd_addr,
    input  logic [31:0]       reg_rd_data,
    output logic              reg_wr_en,
    output logic [REG_AW-1:0] reg_wr_addr,
    output logic [31:0]       reg_wr_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              done,
    output logic              err
);

    localparam logic [DATA_W-1:0] REG_LIMIT = DATA_W'(REG_COUNT);

    typedef struct packed {
        state_e            st;
        logic [DATA_W-1:0] value;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    logic                             last_word;
    logic                             accept;

    assign word_ready = (ctl_q.st == ST_COLLECT);
    assign accept     = word_valid && word_ready;

    cse_payload #(
        .NWORDS (NUM_WORDS),
        .W      (DATA_W)
    ) u_payload (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .din   (word_data),
        .words (words),
        .last  (last_word)
    );

    // Decoded command fields
    logic [DATA_W-1:0]     ctrl_w, poll_w, ref_w, mask_w, waddr_w, wdata_w;
    logic [CTL_CODE_W-1:0] code;
    logic                  src_mem, dst_mem;
    logic                  poll_out_of_range, dest_out_of_range;
    logic                  unused_wait;

    assign ctrl_w  = words[IDX_CTRL];
    assign poll_w  = words[IDX_POLL];
    assign ref_w   = words[IDX_REF];
    assign mask_w  = words[IDX_MASK];
    assign waddr_w = words[IDX_WADDR];
    assign wdata_w = words[IDX_WDATA];
    assign unused_wait = ^{words[IDX_WAIT], ctrl_w};

    assign code    = ctrl_w[CTL_CODE_LO +: CTL_CODE_W];
    assign src_mem = ctrl_w[CTL_SRC_MEM];
    assign dst_mem = ctrl_w[CTL_DST_MEM];

    assign poll_out_of_range = !src_mem && (poll_w >= REG_LIMIT);
    assign dest_out_of_range = !dst_mem && (waddr_w >= REG_LIMIT);

    // Big-endian conversion for both memory directions
    logic [DATA_W-1:0] mem_rd_value;

    cse_byteswap #(.W(DATA_W)) u_swap_rd (
        .din  (mem_rd_data),
        .dout (mem_rd_value)
    );

    cse_byteswap #(.W(DATA_W)) u_swap_wr (
        .din  (wdata_w),
        .dout (mem_wr_data)
    );

    logic cmp_match, cmp_bad;

    cse_compare #(.W(DATA_W)) u_cmp (
        .code  (code),
        .value (ctl_q.value),
        .mask  (mask_w),
        .refv  (ref_w),
        .match (cmp_match),
        .bad   (cmp_bad)
    );

    logic issue_read;
    assign issue_read = (ctl_q.st == ST_ISSUE) && !cmp_bad && !poll_out_of_range;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_COLLECT: begin
                if (last_word) begin
                    ctl_d.st  = ST_ISSUE;
                    ctl_d.err = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (cmp_bad || poll_out_of_range) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_DONE;
                end else begin
                    ctl_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (!src_mem) begin
                    ctl_d.value = reg_rd_data;
                    ctl_d.st    = ST_EVAL;
                end else if (mem_rd_valid) begin
                    ctl_d.value = mem_rd_value;
                    ctl_d.st    = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (!cmp_match) begin
                    ctl_d.st = ST_DONE;
                end else if (dest_out_of_range) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_DONE;
                end else begin
                    ctl_d.st = ST_WRITE;
                end
            end
            ST_WRITE: ctl_d.st = ST_DONE;
            ST_DONE:  ctl_d.st = ST_COLLECT;
            default:  ctl_d.st = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_COLLECT, value: '0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign reg_rd_en   = issue_read && !src_mem;
    assign reg_rd_addr = poll_w[REG_AW-1:0];
    assign mem_rd_req  = issue_read && src_mem;
    assign mem_rd_addr = poll_w[ADDR_W-1:0];

    assign reg_wr_en   = (ctl_q.st == ST_WRITE) && !dst_mem;
    assign reg_wr_addr = waddr_w[REG_AW-1:0];
    assign reg_wr_data = wdata_w;
    assign mem_wr_req  = (ctl_q.st == ST_WRITE) && dst_mem;
    assign mem_wr_addr = waddr_w[ADDR_W-1:0];

    assign done = (ctl_q.st == ST_DONE);
    assign err  = done && ctl_q.err;

    // ---------------- assertions ----------------
    assert_no_ready_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !word_ready);

    assert_one_write_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && mem_wr_req));

    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en || mem_rd_req) |=> !(reg_rd_en || mem_rd_req));

    assert_reg_wr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (REG_AW'(reg_wr_addr) < REG_AW'(REG_COUNT) || REG_COUNT == (1 << REG_AW)));

    assert_reg_rd_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (REG_AW'(reg_rd_addr) < REG_AW'(REG_COUNT) || REG_COUNT == (1 << REG_AW)));

    assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(reg_wr_en || mem_wr_req));

    assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || mem_wr_req) |=> done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

// File: tb/cond_store_engine_test.sv
module cond_store_engine_test;

    localparam int REG_COUNT = 48;
    localparam int REG_AW    = 6;
    localparam int ADDR_W    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_valid = 1'b0;
    logic [31:0]       word_data = '0;
    logic              word_ready;
    logic              reg_rd_en;
    logic [REG_AW-1:0] reg_rd_addr;
    logic [31:0]       reg_rd_data = '0;
    logic              reg_wr_en;
    logic [REG_AW-1:0] reg_wr_addr;
    logic [31:0]       reg_wr_data;
    logic              mem_rd_req;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [31:0]       mem_rd_data = '0;
    logic              mem_wr_req;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [31:0]       mem_wr_data;
    logic              done;
    logic              err;

    always #2 clk = ~clk;

    cond_store_engine #(.REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .err(err)
    );

    // ---------------- models ----------------
    logic [31:0] regs [REG_COUNT];
    logic [7:0]  mem_b [64];
    logic [5:0]  m_addr = '0;
    int          m_wait = 0;

    always @(posedge clk) begin
        if (reg_rd_en) reg_rd_data <= regs[reg_rd_addr];
        if (reg_wr_en) regs[reg_wr_addr] <= reg_wr_data;
        if (mem_wr_req) begin
            for (int k = 0; k < 4; k++) mem_b[(mem_wr_addr[5:0] + 6'(k))] <= mem_wr_data[8*k +: 8];
        end
        mem_rd_valid <= 1'b0;
        if (mem_rd_req) begin
            m_addr <= mem_rd_addr[5:0];
            m_wait <= 2;
        end else if (m_wait != 0) begin
            m_wait <= m_wait - 1;
            if (m_wait == 1) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= {mem_b[m_addr + 6'd3], mem_b[m_addr + 6'd2],
                                 mem_b[m_addr + 6'd1], mem_b[m_addr]};
            end
        end
    end

    // ---------------- monitor ----------------
    int cyc = 0;
    int rd_cnt, reg_wr_cnt, mem_wr_cnt, done_cnt, err_cnt, wr_cyc, done_cyc;
    logic [31:0] last_wr_data;
    logic [REG_AW-1:0] last_wr_addr;
    logic busy = 1'b0;
    logic ready_while_busy;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (reg_rd_en || mem_rd_req) rd_cnt++;
        if (reg_wr_en) begin
            reg_wr_cnt++; wr_cyc = cyc; last_wr_addr = reg_wr_addr; last_wr_data = reg_wr_data;
        end
        if (mem_wr_req) begin
            mem_wr_cnt++; wr_cyc = cyc;
        end
        if (done) begin
            done_cnt++; done_cyc = cyc;
            if (err) err_cnt++;
        end
        if (busy && word_ready && done_cnt == 0) ready_while_busy = 1'b1;
    end

    // ---------------- bookkeeping ----------------
    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic bit ref_match(input int code, input logic [31:0] v, input logic [31:0] m,
                                     input logic [31:0] r);
        logic [31:0] x;
        x = v & m;
        case (code)
            0: return 1'b1;
            1: return x < r;
            2: return x <= r;
            3: return x == r;
            4: return x != r;
            5: return x >= r;
            6: return x > r;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [6:0][31:0] mk(input logic [31:0] ctrl, poll, refv, mask, waitw, waddr, wdata);
        logic [6:0][31:0] c;
        c[0] = ctrl; c[1] = poll; c[2] = refv; c[3] = mask; c[4] = waitw; c[5] = waddr; c[6] = wdata;
        return c;
    endfunction

    function automatic logic [31:0] ctl(input int code, input bit src_mem, input bit dst_mem);
        return 32'(code) | (src_mem ? 32'h10 : 32'h0) | (dst_mem ? 32'h100 : 32'h0);
    endfunction

    task automatic run(input logic [6:0][31:0] c, input int gap);
        rd_cnt = 0; reg_wr_cnt = 0; mem_wr_cnt = 0; done_cnt = 0; err_cnt = 0;
        wr_cyc = -10; done_cyc = -20; ready_while_busy = 1'b0;
        for (int i = 0; i < 7; i++) begin
            for (int g = 0; g < gap; g++) @(posedge clk);
            #1 word_valid = 1'b1; word_data = c[i];
            @(posedge clk);
            #1 word_valid = 1'b0; word_data = 32'hDEAD_BEEF;
            if (i == 6) busy = 1'b1;
        end
        for (int t = 0; t < 100 && done_cnt == 0; t++) @(posedge clk);
        repeat (3) @(posedge clk);
        busy = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(word_ready === 1'b1, "R11 ready", 32'(word_ready), 1);
        check({done, err, reg_rd_en, reg_wr_en, mem_rd_req, mem_wr_req} === 6'b0, "R11 strobes",
              32'({done, err, reg_rd_en, reg_wr_en, mem_rd_req, mem_wr_req}), 0);
    endtask

    task automatic t_reg_to_reg();
        regs[5] = 32'h1234_5678; regs[9] = 32'h0;
        run(mk(ctl(3, 0, 0), 5, 32'h5678, 32'h0000_FFFF, 0, 9, 32'hCAFE_F00D), 0);
        check(reg_wr_cnt == 1 && mem_wr_cnt == 0, "R3 reg dest", 32'(reg_wr_cnt), 1);
        check(regs[9] == 32'hCAFE_F00D, "R2 reg source write", regs[9], 32'hCAFE_F00D);
        check(done_cyc == wr_cyc + 1 && done_cnt == 1, "R10 done after write", 32'(done_cyc - wr_cyc), 1);
        check(rd_cnt == 1 && ready_while_busy == 1'b0, "R1 busy ready low", 32'(ready_while_busy), 0);
    endtask

    task automatic t_sweep();
        logic [31:0] refs [3];
        int errs;
        refs[0] = 32'h4F; refs[1] = 32'h50; refs[2] = 32'h51;
        regs[3] = 32'hABCD_0050;
        errs = 0;
        for (int code = 0; code < 7; code++) begin
            for (int r = 0; r < 3; r++) begin
                run(mk(ctl(code, 0, 0), 3, refs[r], 32'hFF, 0, 10, 32'(code * 16 + r)), 0);
                if (reg_wr_cnt != int'(ref_match(code, 32'hABCD_0050, 32'hFF, refs[r])) || done_cnt != 1) begin
                    errs++;
                    $display("FAIL R4: code %0d ref 0x%0h writes actual %0d expected %0d",
                             code, refs[r], reg_wr_cnt, ref_match(code, 32'hABCD_0050, 32'hFF, refs[r]));
                end
            end
        end
        check(errs == 0, "R4 code sweep", 32'(errs), 0);
    endtask

    task automatic t_mem_to_reg();
        mem_b[16] = 8'h11; mem_b[17] = 8'h22; mem_b[18] = 8'h33; mem_b[19] = 8'h44;
        regs[12] = 0;
        run(mk(ctl(3, 1, 0), 32'h10, 32'h1122_3344, 32'hFFFF_FFFF, 0, 12, 32'h0BAD_F00D), 2);
        check(regs[12] == 32'h0BAD_F00D && rd_cnt == 1, "R2 R6 memory source big-endian", regs[12], 32'h0BAD_F00D);
        run(mk(ctl(3, 1, 0), 32'h10, 32'h4433_2211, 32'hFFFF_FFFF, 0, 12, 32'h1), 0);
        check(reg_wr_cnt == 0, "R6 swapped order misses", 32'(reg_wr_cnt), 0);
    endtask

    task automatic t_reg_to_mem();
        regs[7] = 32'h0000_0009;
        run(mk(ctl(6, 0, 1), 7, 32'h8, 32'hF, 0, 32'h20, 32'hA1B2_C3D4), 0);
        check(mem_wr_cnt == 1 && reg_wr_cnt == 0, "R3 mem dest", 32'(mem_wr_cnt), 1);
        check({mem_b[32], mem_b[33], mem_b[34], mem_b[35]} == 32'hA1B2_C3D4, "R6 write bytes",
              {mem_b[32], mem_b[33], mem_b[34], mem_b[35]}, 32'hA1B2_C3D4);
    endtask

    task automatic t_mem_to_mem();
        mem_b[40] = 8'h00; mem_b[41] = 8'h00; mem_b[42] = 8'h01; mem_b[43] = 8'h00;
        run(mk(ctl(5, 1, 1), 32'h28, 32'h100, 32'hFFFF_FFFF, 0, 32'h2C, 32'h5566_7788), 1);
        check(mem_wr_cnt == 1 && {mem_b[44], mem_b[45], mem_b[46], mem_b[47]} == 32'h5566_7788,
              "R3 mem to mem", {mem_b[44], mem_b[45], mem_b[46], mem_b[47]}, 32'h5566_7788);
    endtask

    task automatic t_fail();
        regs[4] = 32'h10; regs[13] = 32'h7777;
        run(mk(ctl(1, 0, 0), 4, 32'h10, 32'hFFFF_FFFF, 0, 13, 32'h1), 0);
        check(reg_wr_cnt == 0 && mem_wr_cnt == 0 && regs[13] == 32'h7777, "R5 no write on fail", regs[13], 32'h7777);
        check(rd_cnt == 1 && done_cnt == 1 && err_cnt == 0, "R5 single read and done", 32'(rd_cnt), 1);
    endtask

    task automatic t_bad_code();
        run(mk(ctl(7, 0, 0), 4, 0, 0, 0, 14, 32'h1), 0);
        check(err_cnt == 1 && done_cnt == 1 && reg_wr_cnt == 0 && rd_cnt == 0, "R9 code 7", 32'(err_cnt), 1);
    endtask

    task automatic t_range();
        run(mk(ctl(0, 0, 0), 50, 0, 0, 0, 15, 32'h1), 0);
        check(err_cnt == 1 && reg_wr_cnt == 0 && rd_cnt == 0, "R7 poll addr out of range", 32'(err_cnt), 1);
        run(mk(ctl(0, 0, 0), 47, 0, 0, 0, 48, 32'h1), 0);
        check(err_cnt == 1 && reg_wr_cnt == 0, "R7 dest addr 48", 32'(reg_wr_cnt), 0);
        run(mk(ctl(0, 0, 0), 47, 0, 0, 0, 47, 32'h2468), 0);
        check(err_cnt == 0 && reg_wr_cnt == 1 && regs[47] == 32'h2468, "R7 addr 47 ok", regs[47], 32'h2468);
        run(mk(ctl(0, 0, 1), 47, 0, 0, 0, 48, 32'h0102_0304), 0);
        check(err_cnt == 0 && mem_wr_cnt == 1 && mem_b[48] == 8'h01, "R7 mem addr unchecked", 32'(mem_b[48]), 1);
    endtask

    task automatic t_wait_ignored();
        regs[20] = 32'h55;
        run(mk(ctl(3, 0, 0), 20, 32'h55, 32'hFF, 32'hFFFF_FFFF, 21, 32'h99), 0);
        check(reg_wr_cnt == 1 && last_wr_addr == 6'd21 && last_wr_data == 32'h99, "R8 wait word ignored",
              last_wr_data, 32'h99);
        run(mk(ctl(4, 0, 0), 20, 32'h55, 32'hFF, 32'h0000_0055, 21, 32'h98), 0);
        check(reg_wr_cnt == 0 && done_cnt == 1, "R8 wait word no effect on fail", 32'(reg_wr_cnt), 0);
    endtask

    // ---------------- main ----------------
    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < REG_COUNT; i++) regs[i] = '0;
        for (int i = 0; i < 64; i++) mem_b[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_reg_to_reg();
        t_sweep();
        t_mem_to_reg();
        t_reg_to_mem();
        t_mem_to_mem();
        t_fail();
        t_bad_code();
        t_range();
        t_wait_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule